// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small processor core and handles the hardware side of interrupt entry and exit. Request pulses from the timer and bus sources are captured in a pending latch. A single global enable gates them. When the core signals an instruction boundary, the lowest-numbered pending source wins. The sequencer then snapshots the current 14-bit program counter and the carry and zero flags. It writes them as two bytes to data memory at the program stack pointer, which it owns. Once the second byte is accepted, it hands the core the vector address of the winning source.

On a return request the block walks the stack pointer back down. It reads the two saved bytes and hands the core the restored program counter and flags. It can also turn the global enable back on.

Both memory channels use valid/ready:
- **Writes:** the write request holds its address and data steady while ready is low.
- **Reads:** a read request is a valid/ready pair. The memory answers with exactly one response pulse some cycles after accepting it. The response has no back-pressure, because the sequencer is always waiting for it.
- **Stalls:** any number of stall cycles on either ready only delays the sequence. It does not change the sequence.

Top module: `intr_ctx_seq`

## Requirements
- R1: After reset the stack pointer is 0x00, the global enable is off, nothing is pending, no sequence is running, and the jump address reads 0x0000 (execution begins at address zero).
- R2: A one-cycle pulse on a request line stays pending until that source is granted. A grant clears only the granted source's pending bit.
- R3: No sequence starts while the global enable is off or while `take_ok` is low, however long requests stay pending.
- R4: Among pending sources the lowest index wins. Source i jumps to VEC_BASE + VEC_STEP*i: with defaults, 0x0002 for source 0 (bus reset), 0x0004 (128 us tick), 0x0006 (1.024 ms tick), then endpoint sources from 0x0008 upward.
- R5: A grant turns the global enable off in the same edge; a grant outranks a simultaneous enable-set.
- R6: Entry writes two bytes and increments the stack pointer after each one. The first byte goes to SP and holds PC[7:0]. The second goes to SP+1 and holds {carry, zero, PC[13:8]}, with carry in bit 7 and zero in bit 6.
- R7: While a write or read request is valid and not ready, its address and data stay unchanged and it stays valid.
- R8: `jump_valid` pulses for exactly one cycle, in the cycle after the second entry byte is accepted, with `jump_pc` carrying the winning vector.
- R9: A return first decrements SP and reads the high byte there, then decrements again and reads the low byte. It then pulses `restore_valid` for one cycle with PC = {hi[5:0], lo}, carry = hi[7] and zero = hi[6]. The stack pointer moves by 8-bit modulo arithmetic in both directions.
- R10: A return requested with `reti_ien` high turns the global enable on after the restore; with `reti_ien` low the enable stays as it was.
- R11: A stack pointer load takes effect only in an idle cycle in which no sequence starts; during a sequence it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request pulses, bit i = source i |
| take_ok | input | 1 | Core is at an instruction boundary |
| ien_set | input | 1 | Turn global enable on |
| ien_clr | input | 1 | Turn global enable off |
| ien | output | 1 | Global enable state |
| cpu_pc | input | 14 | Current program counter |
| cpu_carry | input | 1 | Current carry flag |
| cpu_zero | input | 1 | Current zero flag |
| reti_req | input | 1 | Start a return sequence |
| reti_ien | input | 1 | Re-enable interrupts after return |
| sp_load | input | 1 | Load stack pointer |
| sp_load_val | input | 8 | Value to load |
| sp | output | 8 | Program stack pointer |
| busy | output | 1 | A sequence is in progress |
| jump_valid | output | 1 | Vector ready pulse |
| jump_pc | output | 14 | Vector address |
| restore_valid | output | 1 | Restored context pulse |
| restore_pc | output | 14 | Restored program counter |
| restore_carry | output | 1 | Restored carry |
| restore_zero | output | 1 | Restored zero |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write byte |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts read |
| rd_addr | output | 8 | Read address |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 8 | Read response byte |

## Verification
The bench builds the block with its defaults: eight sources, base 0x0002 and step 2. This places both the highest-priority vector 0x0002 and the lowest-priority vector 0x0010 among the granted cases. The 8-bit stack pointer is loaded near its top so that an entry wraps from 0xFF to 0x00 and the following return wraps back. Stall patterns on both ready inputs exercise held requests. The scenarios also cover several sources pending at once, reached only through enable toggling.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int PC_W   = 14;
  localparam int SP_W   = 8;
  localparam int BYTE_W = 8;
  localparam int HI_PC  = PC_W - BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI_REQ,
    ST_POP_HI_WAIT,
    ST_POP_LO_REQ,
    ST_POP_LO_WAIT
  } seq_state_e;

  function automatic logic [BYTE_W-1:0] pack_hi(input logic c, input logic z,
                                                input logic [HI_PC-1:0] pch);
    return {c, z, pch};
  endfunction
endpackage

// File: rtl/irq_latch_arb.sv
module irq_latch_arb #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             any,
  output logic [IDX_W-1:0] win_idx
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] clr_mask;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_mask
      assign clr_mask[g] = clr_en && (clr_idx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | req;
  end

  always_comb begin
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) win_idx = IDX_W'(i);
    end
  end

  assign any = |pend_q;
endmodule

// File: rtl/ctx_stack_engine.sv
module ctx_stack_engine
  import intr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_push,
  input  logic [PC_W-1:0]   vec_in,
  input  logic [PC_W-1:0]   ctx_pc,
  input  logic              ctx_c,
  input  logic              ctx_z,
  input  logic              reti_req,
  input  logic              reti_ien,
  input  logic              sp_load,
  input  logic [SP_W-1:0]   sp_load_val,
  output logic [SP_W-1:0]   sp,
  output logic              idle,
  output logic              jump_valid,
  output logic [PC_W-1:0]   jump_pc,
  output logic              restore_valid,
  output logic [PC_W-1:0]   restore_pc,
  output logic              restore_c,
  output logic              restore_z,
  output logic              ien_on_pulse,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [SP_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [SP_W-1:0]   rd_addr,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data
);
  seq_state_e        st_q;
  logic [SP_W-1:0]   sp_q;
  logic [PC_W-1:0]   vec_q;
  logic [BYTE_W-1:0] lo_q, hi_q, pop_hi_q;
  logic              ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      sp_q          <= '0;
      vec_q         <= '0;
      lo_q          <= '0;
      hi_q          <= '0;
      pop_hi_q      <= '0;
      ien_q         <= 1'b0;
      jump_valid    <= 1'b0;
      jump_pc       <= '0;
      restore_valid <= 1'b0;
      restore_pc    <= '0;
      restore_c     <= 1'b0;
      restore_z     <= 1'b0;
      ien_on_pulse  <= 1'b0;
    end else begin
      jump_valid    <= 1'b0;
      restore_valid <= 1'b0;
      ien_on_pulse  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_push) begin
            vec_q <= vec_in;
            lo_q  <= ctx_pc[BYTE_W-1:0];
            hi_q  <= pack_hi(ctx_c, ctx_z, ctx_pc[PC_W-1:BYTE_W]);
            st_q  <= ST_PUSH_LO;
          end else if (reti_req) begin
            ien_q <= reti_ien;
            sp_q  <= sp_q - 1'b1;
            st_q  <= ST_POP_HI_REQ;
          end else if (sp_load) begin
            sp_q <= sp_load_val;
          end
        end
        ST_PUSH_LO: if (wr_ready) begin
          sp_q <= sp_q + 1'b1;
          st_q <= ST_PUSH_HI;
        end
        ST_PUSH_HI: if (wr_ready) begin
          sp_q       <= sp_q + 1'b1;
          jump_valid <= 1'b1;
          jump_pc    <= vec_q;
          st_q       <= ST_IDLE;
        end
        ST_POP_HI_REQ: if (rd_ready) st_q <= ST_POP_HI_WAIT;
        ST_POP_HI_WAIT: if (rsp_valid) begin
          pop_hi_q <= rsp_data;
          sp_q     <= sp_q - 1'b1;
          st_q     <= ST_POP_LO_REQ;
        end
        ST_POP_LO_REQ: if (rd_ready) st_q <= ST_POP_LO_WAIT;
        ST_POP_LO_WAIT: if (rsp_valid) begin
          restore_valid <= 1'b1;
          restore_pc    <= {pop_hi_q[HI_PC-1:0], rsp_data};
          restore_c     <= pop_hi_q[BYTE_W-1];
          restore_z     <= pop_hi_q[BYTE_W-2];
          ien_on_pulse  <= ien_q;
          st_q          <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sp       = sp_q;
  assign idle     = (st_q == ST_IDLE);
  assign wr_valid = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI);
  assign wr_addr  = sp_q;
  assign wr_data  = (st_q == ST_PUSH_HI) ? hi_q : lo_q;
  assign rd_valid = (st_q == ST_POP_HI_REQ) || (st_q == ST_POP_LO_REQ);
  assign rd_addr  = sp_q;
endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq
  import intr_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_BASE = 2,
  parameter int VEC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              take_ok,
  input  logic              ien_set,
  input  logic              ien_clr,
  output logic              ien,
  input  logic [13:0]       cpu_pc,
  input  logic              cpu_carry,
  input  logic              cpu_zero,
  input  logic              reti_req,
  input  logic              reti_ien,
  input  logic              sp_load,
  input  logic [7:0]        sp_load_val,
  output logic [7:0]        sp,
  output logic              busy,
  output logic              jump_valid,
  output logic [13:0]       jump_pc,
  output logic              restore_valid,
  output logic [13:0]       restore_pc,
  output logic              restore_carry,
  output logic              restore_zero,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             any_pend, idle, grant, ien_q, ien_on;
  logic [IDX_W-1:0] win_idx;
  logic [PC_W-1:0]  vec_addr;

  assign grant    = idle && take_ok && ien_q && any_pend && !reti_req;
  assign vec_addr = PC_W'(VEC_BASE) + PC_W'(VEC_STEP) * PC_W'(win_idx);

  irq_latch_arb #(.N_SRC(N_SRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .clr_en  (grant),
    .clr_idx (win_idx),
    .any     (any_pend),
    .win_idx (win_idx)
  );

  ctx_stack_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_push    (grant),
    .vec_in        (vec_addr),
    .ctx_pc        (cpu_pc),
    .ctx_c         (cpu_carry),
    .ctx_z         (cpu_zero),
    .reti_req      (reti_req),
    .reti_ien      (reti_ien),
    .sp_load       (sp_load),
    .sp_load_val   (sp_load_val),
    .sp            (sp),
    .idle          (idle),
    .jump_valid    (jump_valid),
    .jump_pc       (jump_pc),
    .restore_valid (restore_valid),
    .restore_pc    (restore_pc),
    .restore_c     (restore_carry),
    .restore_z     (restore_zero),
    .ien_on_pulse  (ien_on),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_addr       (rd_addr),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (grant)   ien_q <= 1'b0;
    else if (ien_on)  ien_q <= 1'b1;
    else if (ien_clr) ien_q <= 1'b0;
    else if (ien_set) ien_q <= 1'b1;
  end

  assign ien  = ien_q;
  assign busy = !idle;
endmodule

// File: rtl/intr_ctx_seq_chk.sv
module intr_ctx_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ien,
  input logic [7:0] sp,
  input logic       jump_valid,
  input logic       restore_valid,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_addr
);
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_entry_needs_ien_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(ien));

  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !ien);

  assert_sp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> sp == $past(sp) + 8'd1);

  assert_jump_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !jump_valid);

  assert_read_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);

  assert_restore_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !restore_valid);
endmodule

bind intr_ctx_seq intr_ctx_seq_chk u_chk (.*);

// File: tb/intr_ctx_seq_test.sv
module intr_ctx_seq_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         take_ok = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
  logic         ien;
  logic [13:0]  cpu_pc = '0;
  logic         cpu_carry = 1'b0, cpu_zero = 1'b0;
  logic         reti_req = 1'b0, reti_ien = 1'b0;
  logic         sp_load = 1'b0;
  logic [7:0]   sp_load_val = '0;
  logic [7:0]   sp;
  logic         busy, jump_valid, restore_valid, restore_carry, restore_zero;
  logic [13:0]  jump_pc, restore_pc;
  logic         wr_valid, wr_ready, rd_valid, rd_ready, rsp_valid;
  logic [7:0]   wr_addr, wr_data, rd_addr, rsp_data;

  intr_ctx_seq uut (.*);

  always #2 clk = ~clk;

  typedef struct {
    int          kind;
    logic [13:0] a;
    logic [15:0] d;
    string       req;
  } item_t;
  localparam int K_WR = 0, K_RD = 1, K_JMP = 2, K_RST = 3;

  item_t       sbq[$];
  logic [15:0] ctxq[$];
  logic [7:0]  ram [256];
  logic [7:0]  esp = 8'h00;
  int          n_chk = 0, n_fail = 0, cyc = 0, stall = 0;
  bit          rsp_pend = 0;
  logic [7:0]  rsp_byte = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic observe(input int kind, input logic [13:0] a, input logic [15:0] d);
    item_t e;
    if (sbq.size() == 0) begin
      chk(0, "R3", $sformatf("unexpected event kind %0d", kind), int'(a), -1);
      return;
    end
    e = sbq.pop_front();
    chk(e.kind == kind && e.a == a && e.d == d, e.req,
        $sformatf("event kind %0d/%0d data 0x%0h/0x%0h", kind, e.kind, d, e.d),
        int'(a), int'(e.a));
  endtask

  task automatic push_item(input int kind, input logic [13:0] a,
                           input logic [15:0] d, input string req);
    item_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic expect_irq(input int idx, input logic [13:0] pc,
                            input logic c, input logic z);
    push_item(K_WR, 14'(esp), 16'(pc[7:0]), "R6");
    push_item(K_WR, 14'(8'(esp + 8'd1)), 16'({c, z, pc[13:8]}), "R6");
    push_item(K_JMP, 14'(2 + 2 * idx), 16'h0, "R4 R8");
    esp = esp + 8'd2;
    ctxq.push_back({c, z, pc});
  endtask

  task automatic expect_reti();
    logic [15:0] cx;
    cx = ctxq.pop_back();
    esp = esp - 8'd1;
    push_item(K_RD, 14'(esp), 16'h0, "R9");
    esp = esp - 8'd1;
    push_item(K_RD, 14'(esp), 16'h0, "R9");
    push_item(K_RST, cx[13:0], 16'(cx[15:14]), "R9");
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (sbq.size() != 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(sbq.size() == 0, req, "scoreboard drained", sbq.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_irq(input logic [N-1:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic pulse_set();
    @(negedge clk); ien_set = 1'b1;
    @(negedge clk); ien_set = 1'b0;
  endtask

  task automatic do_reti(input logic en);
    @(negedge clk); reti_req = 1'b1; reti_ien = en;
    @(negedge clk); reti_req = 1'b0; reti_ien = 1'b0;
  endtask

  // memory model and scoreboard monitor
  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    wr_ready = 1'b1; rd_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      wr_ready  = (stall != 0) ? (cyc % 3 == 0) : 1'b1;
      rd_ready  = (stall != 0) ? (cyc % 4 == 1) : 1'b1;
      rsp_valid = rsp_pend;
      rsp_data  = rsp_byte;
      rsp_pend  = 0;
      #1;
      if (rst_n) begin
        if (wr_valid && wr_ready) begin
          ram[wr_addr] = wr_data;
          observe(K_WR, 14'(wr_addr), 16'(wr_data));
        end
        if (rd_valid && rd_ready) begin
          rsp_pend = 1;
          rsp_byte = ram[rd_addr];
          observe(K_RD, 14'(rd_addr), 16'h0);
        end
        if (jump_valid) observe(K_JMP, jump_pc, 16'h0);
        if (restore_valid)
          observe(K_RST, restore_pc, 16'({restore_carry, restore_zero}));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(sp == 8'h00, "R1", "sp after reset", sp, 0);
    chk(ien == 1'b0, "R1", "enable after reset", ien, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(jump_pc == 14'h0, "R1", "jump_pc after reset", jump_pc, 0);
    chk(!jump_valid && !wr_valid && !rd_valid, "R1", "outputs idle", 1, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: enable off blocks entry
    take_ok = 1'b1;
    pulse_irq(8'b0000_0100);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R3", "no entry with enable off", busy, 0);
    // R3: take_ok low blocks entry
    take_ok = 1'b0;
    pulse_set();
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R3", "no entry with take_ok low", busy, 0);
    chk(ien == 1'b1, "R3", "enable set", ien, 1);
    cpu_pc = 14'h2A5B; cpu_carry = 1'b1; cpu_zero = 1'b0;
    expect_irq(2, 14'h2A5B, 1'b1, 1'b0);
    @(negedge clk); take_ok = 1'b1;
    drain("R2");
    chk(ien == 1'b0, "R5", "enable cleared by entry", ien, 0);
    chk(sp == esp, "R6", "sp after entry", sp, esp);

    // R2/R4: several pending, lowest index first
    pulse_irq(8'b0010_0010);
    cpu_pc = 14'h1234; cpu_carry = 1'b0; cpu_zero = 1'b1;
    expect_irq(1, 14'h1234, 1'b0, 1'b1);
    pulse_set();
    drain("R4");
    pulse_irq(8'b1000_0001);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && ien == 1'b0, "R5", "only one entry per enable", ien, 0);
    cpu_pc = 14'h3FFF; cpu_carry = 1'b1; cpu_zero = 1'b1;
    expect_irq(0, 14'h3FFF, 1'b1, 1'b1);
    pulse_set();
    drain("R4");
    cpu_pc = 14'h0100; cpu_carry = 1'b0; cpu_zero = 1'b0;
    expect_irq(5, 14'h0100, 1'b0, 1'b0);
    pulse_set();
    drain("R2");
    cpu_pc = 14'h00C3; cpu_carry = 1'b1; cpu_zero = 1'b0;
    expect_irq(7, 14'h00C3, 1'b1, 1'b0);
    pulse_set();
    drain("R2");
    chk(sp == 8'h0A, "R6", "sp after five entries", sp, 8'h0A);

    // R9/R10/R7: returns under stalls
    take_ok = 1'b0;
    stall = 1;
    expect_reti();
    do_reti(1'b0);
    drain("R9");
    chk(ien == 1'b0, "R10", "enable stays off", ien, 0);
    chk(sp == esp, "R9", "sp after return", sp, esp);
    expect_reti();
    do_reti(1'b1);
    drain("R9");
    chk(ien == 1'b1, "R10", "enable restored", ien, 1);

    // R11: load ignored while busy, honoured when idle
    take_ok = 1'b1;
    cpu_pc = 14'h0777; cpu_carry = 1'b0; cpu_zero = 1'b1;
    expect_irq(3, 14'h0777, 1'b0, 1'b1);
    pulse_irq(8'b0000_1000);
    while (!busy) @(negedge clk);
    sp_load = 1'b1; sp_load_val = 8'h80;
    @(negedge clk); sp_load = 1'b0;
    drain("R11");
    chk(sp == esp, "R11", "load ignored when busy", sp, esp);
    @(negedge clk); sp_load = 1'b1; sp_load_val = 8'hFE;
    @(negedge clk); sp_load = 1'b0;
    @(negedge clk);
    chk(sp == 8'hFE, "R11", "load when idle", sp, 8'hFE);
    esp = 8'hFE;

    // R9: wrap of the 8-bit pointer in both directions
    stall = 0;
    cpu_pc = 14'h2B0D; cpu_carry = 1'b1; cpu_zero = 1'b1;
    expect_irq(4, 14'h2B0D, 1'b1, 1'b1);
    pulse_irq(8'b0001_0000);
    pulse_set();
    drain("R9");
    chk(sp == 8'h00, "R9", "sp wraps up", sp, 0);
    take_ok = 1'b0;
    expect_reti();
    do_reti(1'b0);
    drain("R9");
    chk(sp == 8'hFE, "R9", "sp wraps down", sp, 8'hFE);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule